// File: doc/BRIEF.md
# Page-Wrapping Word Address Pointer

This block keeps the internal word address of a serial memory slave. It is shared by write and read traffic. The protocol front end does one of three things to it. It loads the word address received during an address phase. It pulses a write strobe after each data byte that is stored. It pulses a read strobe after each byte that is returned. The pointer output always holds the location that the next access will use. A read with no address phase can therefore start at the byte after the one last touched.

A write step advances only the low in-page bits and wraps them within the page, so the page index stays fixed. If more bytes arrive than a page holds, the address comes back to the first byte of the page, and that byte is written over. A read step advances the full pointer and wraps from the top of the space back to zero. A load always wins over a step in the same cycle. If both strobes arrive together, the write rule applies and the pointer moves one step.

The defaults are a 9-bit pointer (512 words) and 4 in-page bits (16-byte pages), so the page index is bits [8:4]. The reset input is asynchronous and active low. Its release is synchronised to the clock inside the block, so the pointer leaves reset two clock edges after the input rises.

Top module: `word_addr_ptr`

## Requirements
- R1: While reset is active, and after it is released, the pointer reads 0 until the first load or step takes effect.
- R2: When `ld_en` is 1 at a clock edge, the pointer equals `ld_addr` after that edge.
- R3: A write step (`ld_en`=0, `step_wr`=1) adds 1 to the low PAGE_BITS bits (bits [3:0] by default) and leaves the page bits [8:4] unchanged.
- R4: A write step from in-page offset 15 returns the offset to 0 in the same page (for example 0x1F becomes 0x10, and 0x1FF becomes 0x1F0).
- R5: A read step alone (`ld_en`=0, `step_rd`=1, `step_wr`=0) adds 1 to the whole pointer, modulo 512, so 511 becomes 0 and offset 15 carries into the next page.
- R6: A load in the same cycle as either step or both steps sets the pointer to `ld_addr`, and the steps are ignored.
- R7: Write and read steps together without a load move the pointer by exactly one step under the write rule of R3 and R4.
- R8: With no load and no step, the pointer keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ld_en | input | 1 | Load the pointer from `ld_addr` |
| ld_addr | input | ADDR_W (9) | Word address taken from the address phase |
| step_wr | input | 1 | Advance after a stored byte, using the in-page wrap |
| step_rd | input | 1 | Advance after a returned byte, using the full-space wrap |
| ptr | output | ADDR_W (9) | Address of the next access |

## Verification
Three events can fall in the same cycle: a load, a write step and a read step. The bench raises `ld_en` together with one or both strobes. It also drives both strobes without a load. A reference model in the bench applies load priority and then the write rule, and the registered pointer is compared with it one edge later. The directed cases put these collisions at offset 15 and at address 511, where the write rule and the read rule give different results.

// File: rtl/wap_pkg.sv
package wap_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_LOAD = 2'd1,
    STEP_PAGE = 2'd2,
    STEP_FULL = 2'd3
  } step_kind_e;
endpackage

// File: rtl/wap_rst_sync.sv
module wap_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/wap_step_sel.sv
module wap_step_sel
  import wap_pkg::*;
(
  input  logic       ld_en,
  input  logic       step_wr,
  input  logic       step_rd,
  output step_kind_e kind
);
  // Priority: load, then the write (in-page) step, then the read (full) step.
  always_comb begin
    if (ld_en)        kind = STEP_LOAD;
    else if (step_wr) kind = STEP_PAGE;
    else if (step_rd) kind = STEP_FULL;
    else              kind = STEP_HOLD;
  end
endmodule

// File: rtl/wap_step_math.sv
module wap_step_math #(
  parameter int ADDR_W    = 9,
  parameter int PAGE_BITS = 4
) (
  input  logic [ADDR_W-1:0] cur,
  output logic [ADDR_W-1:0] page_next,
  output logic [ADDR_W-1:0] full_next
);
  logic [PAGE_BITS-1:0] low_inc;

  assign low_inc = cur[PAGE_BITS-1:0] + PAGE_BITS'(1);

  generate
    if (PAGE_BITS < ADDR_W) begin : g_paged
      assign page_next = {cur[ADDR_W-1:PAGE_BITS], low_inc};
    end else begin : g_flat
      assign page_next = low_inc[ADDR_W-1:0];
    end
  endgenerate

  assign full_next = cur + ADDR_W'(1);
endmodule

// File: rtl/word_addr_ptr.sv
module word_addr_ptr
  import wap_pkg::*;
#(
  parameter int ADDR_W     = 9,
  parameter int PAGE_BITS  = 4,
  parameter int SYNC_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              step_wr,
  input  logic              step_rd,
  output logic [ADDR_W-1:0] ptr
);
  localparam int HI_W = ADDR_W - PAGE_BITS;

  logic              rst_sync_n;
  step_kind_e        kind;
  logic [ADDR_W-1:0] page_next;
  logic [ADDR_W-1:0] full_next;
  logic [ADDR_W-1:0] ptr_d;
  logic [ADDR_W-1:0] ptr_q;
  logic              ptr_en;

  wap_rst_sync #(.STAGES(SYNC_STAGE)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  wap_step_sel u_sel (
    .ld_en   (ld_en),
    .step_wr (step_wr),
    .step_rd (step_rd),
    .kind    (kind)
  );

  wap_step_math #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_math (
    .cur       (ptr_q),
    .page_next (page_next),
    .full_next (full_next)
  );

  // Next-state selection and clock enable.
  always_comb begin
    ptr_en = 1'b1;
    ptr_d  = ptr_q;
    unique case (kind)
      STEP_LOAD: ptr_d = ld_addr;
      STEP_PAGE: ptr_d = page_next;
      STEP_FULL: ptr_d = full_next;
      default:   ptr_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  ptr_q <= '0;
    else if (ptr_en)  ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

  // R2
  load_take_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ld_en |=> (ptr == $past(ld_addr)));

  // R3
  page_step_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!ld_en && step_wr) |=>
      ((ptr[PAGE_BITS-1:0] == $past(ptr[PAGE_BITS-1:0]) + PAGE_BITS'(1)) &&
       (ptr[ADDR_W-1:ADDR_W-HI_W] == $past(ptr[ADDR_W-1:ADDR_W-HI_W]))));

  // R5
  full_step_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!ld_en && !step_wr && step_rd) |=> (ptr == $past(ptr) + ADDR_W'(1)));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!ld_en && !step_wr && !step_rd) |=> $stable(ptr));

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    !rst_sync_n |-> (ptr == '0));
endmodule

// File: tb/test_word_addr_ptr.sv
module test_word_addr_ptr;
  localparam int AW = 9;
  localparam int PB = 4;

  logic          clk;
  logic          rst_n;
  logic          ld_en;
  logic [AW-1:0] ld_addr;
  logic          step_wr;
  logic          step_rd;
  logic [AW-1:0] ptr;

  int total;
  int bad;
  logic [AW-1:0] model;

  word_addr_ptr #(.ADDR_W(AW), .PAGE_BITS(PB)) i_word_addr_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_en   (ld_en),
    .ld_addr (ld_addr),
    .step_wr (step_wr),
    .step_rd (step_rd),
    .ptr     (ptr)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [AW-1:0] ref_next(logic [AW-1:0] cur, logic l,
      logic [AW-1:0] a, logic w, logic r);
    logic [PB-1:0] lo;
    if (l) return a;
    if (w) begin
      lo = cur[PB-1:0] + PB'(1);
      return {cur[AW-1:PB], lo};
    end
    if (r) return cur + AW'(1);
    return cur;
  endfunction

  task automatic check(string req, logic [AW-1:0] exp);
    total++;
    if (ptr !== exp) begin
      bad++;
      $display("FAIL %s: ptr=%0h expected=%0h", req, ptr, exp);
    end
  endtask

  // Drive one cycle at the falling edge, then compare after the rising edge.
  task automatic cyc(string req, logic l, logic [AW-1:0] a, logic w, logic r);
    @(negedge clk);
    ld_en = l; ld_addr = a; step_wr = w; step_rd = r;
    model = ref_next(model, l, a, w, r);
    @(posedge clk);
    #2;
    check(req, model);
  endtask

  initial begin
    #1500000;
    bad++;
    $display("FAIL watchdog: ptr=%0h expected=finish", ptr);
    $display("test done: total=%0d bad=%0d", total + 1, bad);
    $finish;
  end

  initial begin
    int seed;
    total = 0; bad = 0;
    rst_n = 1'b0; ld_en = 1'b0; ld_addr = '0; step_wr = 1'b0; step_rd = 1'b0;
    model = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 in reset", '0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    check("R1 after release", '0);

    // Directed corner cases.
    cyc("R8 hold", 0, 9'h0AA, 0, 0);
    cyc("R2 load", 1, 9'h01E, 0, 0);
    cyc("R3 page step", 0, '0, 1, 0);
    cyc("R4 page wrap", 0, '0, 1, 0);
    if (ptr !== 9'h010) begin bad++; $display("FAIL R4: ptr=%0h expected=10", ptr); end
    total++;
    cyc("R2 load top", 1, 9'h1FF, 0, 0);
    cyc("R4 page wrap top", 0, '0, 1, 0);
    cyc("R2 load top", 1, 9'h1FF, 0, 0);
    cyc("R5 full wrap", 0, '0, 0, 1);
    cyc("R2 load", 1, 9'h02F, 0, 0);
    cyc("R5 page carry", 0, '0, 0, 1);
    cyc("R6 load beats steps", 1, 9'h155, 1, 1);
    cyc("R6 load beats wr", 1, 9'h13F, 1, 0);
    cyc("R7 both steps", 0, '0, 1, 1);
    cyc("R6 load beats rd", 1, 9'h1FF, 0, 1);
    cyc("R7 both steps top", 0, '0, 1, 1);
    for (int i = 0; i < 20; i++) cyc("R4 overrun", 0, '0, 1, 0);
    cyc("R8 hold", 0, 9'h123, 0, 0);

    // Constrained random mix.
    seed = $urandom(32'h5EED);
    for (int i = 0; i < 4000; i++) begin
      int pick;
      logic l, w, r;
      pick = int'($urandom_range(99));
      l = (pick < 12);
      w = (pick >= 8 && pick < 55);
      r = (pick >= 45 && pick < 90);
      cyc(l ? "R6/R2 rand" : (w && r) ? "R7 rand" : w ? "R3 rand" :
          r ? "R5 rand" : "R8 rand", l, AW'($urandom_range(511)), w, r);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule